// File: doc/BRIEF.md
# Escalating Multi-Channel Watchdog

The block holds a small, parameterized number of independent watchdog channels behind a single 64-bit register port. Each channel counts down from a reload value. The reload value is a 16-bit length placed above eight zero bits, which makes a 24-bit count. The count moves one step per prescaler period, and the default period is 1024 clocks. When a channel runs out, it reloads and advances one escalation stage. The first stage raises a CPU interrupt. The second raises a management-processor interrupt. The third requests a system reset. The 2-bit mode of the channel decides how far the escalation may go.

Software keeps a channel alive by writing the value 1 to the channel's keepalive register. This reloads the count, restarts the prescaler and sends the escalation back to the first stage. CPU interrupts are latched in a pending register, which software clears by writing 1 to a bit. Each channel also has an enable bit, with separate write-1-to-set and write-1-to-clear addresses. The CPU interrupt output combines the pending and enable bits of all channels. The management interrupt and the reset request are level outputs collected over all channels. The reset request is sticky and only a block reset removes it.

Top module: `esc_wdog`

## Requirements
- R1: After reset, `cpu_irq`, `mgmt_irq` and `rst_req` are 0. Every configuration word, the pending register and the enable register read as 0.
- R2: Channel c has its configuration word at byte address 8*c. The mode is in bits 1:0, the length in bits 19:4 and the live count in bits 43:20. Writing the word loads the count with length*256 and restarts the prescaler. The pending register is at 0x200. The enable register can be read and write-1-cleared at 0x210, and read and write-1-set at 0x218. Keepalive registers start at 0x10000 with an 8-byte stride. A read returns its data on `reg_rdata` one cycle after `reg_rd_en`.
- R3: In mode 0 the count is frozen and the channel raises nothing.
- R4: When the channel is running, the first expiration occurs (length*256+1)*TICK_DIV cycles after the edge that loaded the count. At that expiration the channel's pending bit becomes 1 and the count reloads.
- R5: When the channel is running, the count decreases by exactly one every TICK_DIV clocks.
- R6: Mode 1 raises the CPU interrupt on every expiration and never raises the management interrupt or the reset request.
- R7: Mode 2 raises the CPU interrupt on the first expiration and sets `mgmt_irq` on the second. Later expirations do nothing. Setting mode 0 or a keepalive clears the management flag.
- R8: Mode 3 also asserts `rst_req` on the third expiration. `rst_req` then stays at 1 through keepalives and mode changes, until `rst_n` is applied.
- R9: A write of exactly 1 to a keepalive register reloads the count, restarts the prescaler and returns the escalation to stage one. A write of any other value to a keepalive register has no effect.
- R10: An expiration sets the pending bit even when the enable bit is clear. `cpu_irq` is the OR over channels of pending AND enable. Writing 1 to a pending bit clears it, and writing 0 has no effect.
- R11: Writing a 1 to a bit at the set or clear address sets or clears that channel's enable bit, and 0 bits leave their enable bits unchanged.
- R12: With length 0, a running channel expires on the first prescaler tick, TICK_DIV cycles after the load.
- R13: A keepalive restarts the prescaler from zero, so the next tick comes a full TICK_DIV cycles after the keepalive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 17 | Byte address, 8-byte aligned |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid one cycle after the strobe |
| cpu_irq | output | 1 | OR of enabled pending bits |
| mgmt_irq | output | 1 | Any channel has reached its second stage |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A register write takes effect at the clock edge that samples it, so every output flag and enable or pending change can be seen at the falling edge that follows that clock edge. Read data appears at the falling edge after the read strobe is sampled. The bench counts falling edges starting from the edge that loaded a count. An expiration is therefore due at count (length*256+1)*TICK_DIV. A second-stage or third-stage event is due at two or three times that period. The bench checks for the exact count at which a flag first rises, not merely for a rise before a limit. That catches an off-by-one in the prescaler or in the count.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;
  localparam int MODE_W   = 2;
  localparam int LEN_W    = 16;
  localparam int LOW_ZERO = 8;
  localparam int CNT_W    = LEN_W + LOW_ZERO;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 17;
  localparam int WORD_W   = ADDR_W - 3;

  localparam int MODE_LSB = 0;
  localparam int LEN_LSB  = 4;
  localparam int CNT_LSB  = 20;

  localparam int PEND_WORD  = 'h40;
  localparam int ENCLR_WORD = 'h42;
  localparam int ENSET_WORD = 'h43;
  localparam int POKE_WORD  = 'h2000;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_CPU      = 2'd1,
    MODE_CPU_MGMT = 2'd2,
    MODE_FULL     = 2'd3
  } wd_mode_e;

  typedef enum logic [1:0] {
    STG_FIRST  = 2'd0,
    STG_SECOND = 2'd1,
    STG_THIRD  = 2'd2
  } wd_stage_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_PEND = 2'd2,
    RD_EN   = 2'd3
  } rd_kind_e;

  function automatic logic [CNT_W-1:0] reload_of(input logic [LEN_W-1:0] len);
    return {len, {LOW_ZERO{1'b0}}};
  endfunction

  function automatic wd_stage_e next_stage(input wd_mode_e m, input wd_stage_e s);
    if (m == MODE_CPU) return STG_FIRST;
    case (s)
      STG_FIRST:  return STG_SECOND;
      STG_SECOND: return STG_THIRD;
      default:    return STG_THIRD;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(input logic [MODE_W-1:0] m,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic [CNT_W-1:0] cnt);
    logic [DATA_W-1:0] r;
    r = '0;
    r[MODE_LSB +: MODE_W] = m;
    r[LEN_LSB  +: LEN_W]  = len;
    r[CNT_LSB  +: CNT_W]  = cnt;
    return r;
  endfunction
endpackage

// File: rtl/esc_wdog_regdec.sv
module esc_wdog_regdec
  import esc_wdog_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] poke_we,
  output logic              pend_clr_we,
  output logic              en_set_we,
  output logic              en_clr_we,
  output rd_kind_e          rd_kind,
  output logic [CH_W-1:0]   rd_ch
);
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [NUM_CH-1:0] cfg_hit;
  logic [NUM_CH-1:0] poke_hit;
  logic              poke_one;
  logic              pend_hit, enclr_hit, enset_hit;

  assign aligned  = (addr[2:0] == 3'b000);
  assign word     = addr[ADDR_W-1:3];
  assign poke_one = (wdata == DATA_W'(1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign cfg_hit[i]  = aligned && (word == WORD_W'(i));
    assign poke_hit[i] = aligned && (word == WORD_W'(POKE_WORD + i));
  end

  assign pend_hit  = aligned && (word == WORD_W'(PEND_WORD));
  assign enclr_hit = aligned && (word == WORD_W'(ENCLR_WORD));
  assign enset_hit = aligned && (word == WORD_W'(ENSET_WORD));

  assign cfg_we      = {NUM_CH{wr_en}} & cfg_hit;
  assign poke_we     = {NUM_CH{wr_en && poke_one}} & poke_hit;
  assign pend_clr_we = wr_en && pend_hit;
  assign en_set_we   = wr_en && enset_hit;
  assign en_clr_we   = wr_en && enclr_hit;

  always_comb begin
    rd_ch = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (cfg_hit[i]) rd_ch = CH_W'(i);
  end

  always_comb begin
    if (|cfg_hit)                   rd_kind = RD_CFG;
    else if (pend_hit)              rd_kind = RD_PEND;
    else if (enclr_hit || enset_hit) rd_kind = RD_EN;
    else                            rd_kind = RD_NONE;
  end

  always_comb begin
    assert_dec_onehot_R2: assert ($onehot0(cfg_we | poke_we));
  end
endmodule

// File: rtl/esc_wdog_chan.sv
module esc_wdog_chan
  import esc_wdog_pkg::*;
#(
  parameter int TICK_DIV = 1024,
  localparam int PS_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              poke_we,
  output logic [MODE_W-1:0] mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_cpu,
  output logic              mgmt_flag,
  output logic              rst_flag
);
  wd_mode_e         mode_q;
  wd_stage_e        stage_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  presc_q;

  logic tick, expire, expire_mgmt, expire_rst, running, restart;

  assign running     = (mode_q != MODE_OFF);
  assign restart     = cfg_we || poke_we;
  assign tick        = running && (presc_q == PS_W'(TICK_DIV - 1));
  assign expire      = tick && !restart && (cnt_q == '0);
  assign expire_cpu  = expire && ((stage_q == STG_FIRST) || (mode_q == MODE_CPU));
  assign expire_mgmt = expire && (stage_q == STG_SECOND) &&
                       ((mode_q == MODE_CPU_MGMT) || (mode_q == MODE_FULL));
  assign expire_rst  = expire && (stage_q == STG_THIRD) && (mode_q == MODE_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      len_q     <= '0;
      cnt_q     <= '0;
      presc_q   <= '0;
      stage_q   <= STG_FIRST;
      mgmt_flag <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= wd_mode_e'(cfg_mode);
      len_q   <= cfg_len;
      cnt_q   <= reload_of(cfg_len);
      presc_q <= '0;
      if (wd_mode_e'(cfg_mode) == MODE_OFF) begin
        stage_q   <= STG_FIRST;
        mgmt_flag <= 1'b0;
      end
    end else if (poke_we) begin
      cnt_q     <= reload_of(len_q);
      presc_q   <= '0;
      stage_q   <= STG_FIRST;
      mgmt_flag <= 1'b0;
    end else if (running) begin
      presc_q <= tick ? '0 : presc_q + 1'b1;
      if (tick) begin
        if (expire) begin
          cnt_q   <= reload_of(len_q);
          stage_q <= next_stage(mode_q, stage_q);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (expire_mgmt) mgmt_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rst_flag <= 1'b0;
    else if (expire_rst) rst_flag <= 1'b1;
  end

  assign mode_o = mode_q;
  assign len_o  = len_q;
  assign cnt_o  = cnt_q;

  assert_poke_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (poke_we && !cfg_we) |=> (cnt_q == reload_of(len_q)) && (stage_q == STG_FIRST) && !mgmt_flag);

  assert_off_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF && !restart) |=> $stable(cnt_q) && !mgmt_flag);

  assert_expire_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == reload_of(len_q)));

  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_stage_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q != 2'd3);

  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |=> rst_flag);

  assert_mode1_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CPU && !mgmt_flag && !cfg_we) |=> !mgmt_flag);
endmodule

// File: rtl/esc_wdog_irq.sv
module esc_wdog_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_pend,
  input  logic              pend_clr_we,
  input  logic              en_set_we,
  input  logic              en_clr_we,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] en_q,
  output logic              cpu_irq
);
  logic [NUM_CH-1:0] clr_bits;

  assign clr_bits = pend_clr_we ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | set_pend;
      if (en_set_we)      en_q <= en_q | mask;
      else if (en_clr_we) en_q <= en_q & ~mask;
    end
  end

  assign cpu_irq = |(pend_q & en_q);

  assert_pend_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pend) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));

  assert_pend_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_we |=> ((pend_q & $past(mask & ~set_pend)) == '0));

  assert_en_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((en_q & $past(mask)) == $past(mask)));

  assert_en_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((en_q & $past(mask)) == '0));
endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import esc_wdog_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int TICK_DIV = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [16:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              cpu_irq,
  output logic              mgmt_irq,
  output logic              rst_req
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] cfg_we, poke_we, expire_cpu, mgmt_flags, rst_flags;
  logic [NUM_CH-1:0] pend_q, en_q;
  logic              pend_clr_we, en_set_we, en_clr_we;
  rd_kind_e          rd_kind;
  logic [CH_W-1:0]   rd_ch;
  logic [MODE_W-1:0] mode_a [NUM_CH];
  logic [LEN_W-1:0]  len_a  [NUM_CH];
  logic [CNT_W-1:0]  cnt_a  [NUM_CH];
  logic [DATA_W-1:0] rd_mux;

  esc_wdog_regdec #(.NUM_CH(NUM_CH)) dec_i (
    .wr_en       (reg_wr_en),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .cfg_we      (cfg_we),
    .poke_we     (poke_we),
    .pend_clr_we (pend_clr_we),
    .en_set_we   (en_set_we),
    .en_clr_we   (en_clr_we),
    .rd_kind     (rd_kind),
    .rd_ch       (rd_ch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    esc_wdog_chan #(.TICK_DIV(TICK_DIV)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we[i]),
      .cfg_mode   (reg_wdata[MODE_LSB +: MODE_W]),
      .cfg_len    (reg_wdata[LEN_LSB +: LEN_W]),
      .poke_we    (poke_we[i]),
      .mode_o     (mode_a[i]),
      .len_o      (len_a[i]),
      .cnt_o      (cnt_a[i]),
      .expire_cpu (expire_cpu[i]),
      .mgmt_flag  (mgmt_flags[i]),
      .rst_flag   (rst_flags[i])
    );
  end

  esc_wdog_irq #(.NUM_CH(NUM_CH)) irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_pend    (expire_cpu),
    .pend_clr_we (pend_clr_we),
    .en_set_we   (en_set_we),
    .en_clr_we   (en_clr_we),
    .mask        (reg_wdata[NUM_CH-1:0]),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .cpu_irq     (cpu_irq)
  );

  always_comb begin
    case (rd_kind)
      RD_CFG:  rd_mux = pack_cfg(mode_a[rd_ch], len_a[rd_ch], cnt_a[rd_ch]);
      RD_PEND: rd_mux = DATA_W'(pend_q);
      RD_EN:   rd_mux = DATA_W'(en_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end

  assign mgmt_irq = |mgmt_flags;
  assign rst_req  = |rst_flags;

  assert_rst_out_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !cpu_irq);
endmodule

// File: tb/esc_wdog_tb_top.sv
module esc_wdog_tb_top;
  localparam int NCH = 4;
  localparam int DIV = 4;
  localparam logic [16:0] A_PEND  = 17'h200;
  localparam logic [16:0] A_ENCLR = 17'h210;
  localparam logic [16:0] A_ENSET = 17'h218;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [16:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        cpu_irq, mgmt_irq, rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  esc_wdog #(.NUM_CH(NCH), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .cpu_irq(cpu_irq), .mgmt_irq(mgmt_irq), .rst_req(rst_req)
  );

  function automatic logic [16:0] cfg_a(input int ch);  return 17'(ch * 8); endfunction
  function automatic logic [16:0] poke_a(input int ch); return 17'('h10000 + ch * 8); endfunction
  function automatic logic [63:0] cfg_v(input int m, input int len);
    return 64'(m & 3) | (64'(len & 'hFFFF) << 4);
  endfunction
  function automatic logic [63:0] cfg_rb(input int m, input int len, input int cnt);
    return cfg_v(m, len) | (64'(cnt & 'hFFFFFF) << 20);
  endfunction
  function automatic int expiry_cycles(input int len); return (len * 256 + 1) * DIV; endfunction
  function automatic logic sig(input int w);
    case (w)
      0: return cpu_irq;
      1: return mgmt_irq;
      default: return rst_req;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [63:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic measure(input int w, input int start, input int limit, output int n);
    n = start;
    while (!sig(w) && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [3:0]  model;
    int n, t;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 cpu_irq", cpu_irq, 0);
    chk("R1 mgmt_irq", mgmt_irq, 0);
    chk("R1 rst_req", rst_req, 0);
    rd(cfg_a(1), d); chk("R1 cfg", d, 0);
    rd(A_PEND, d);   chk("R1 pend", d, 0);
    rd(A_ENSET, d);  chk("R1 en", d, 0);

    // R11 random enable set/clear against a model
    model = '0;
    for (int it = 0; it < 30; it++) begin
      logic [3:0] m;
      logic s;
      m = 4'($urandom);
      s = 1'($urandom);
      if (it % 7 == 0) m = '0;
      if (s) begin wr(A_ENSET, 64'(m)); model = model | m; end
      else   begin wr(A_ENCLR, 64'(m)); model = model & ~m; end
      rd(s ? A_ENCLR : A_ENSET, d);
      chk("R11 enable", d, 64'(model));
    end
    wr(A_ENCLR, 64'hF);
    wr(A_ENSET, 64'h7);

    // R2 field layout, R3 mode 0 frozen
    wr(cfg_a(2), cfg_v(0, 'hABCD));
    rd(cfg_a(2), d); chk("R2 cfg fields", d, cfg_rb(0, 'hABCD, 'hABCD00));
    repeat (50) @(negedge clk);
    rd(cfg_a(2), d); chk("R3 frozen count", d, cfg_rb(0, 'hABCD, 'hABCD00));
    chk("R3 no irq", cpu_irq, 0);
    rd(A_PEND, d); chk("R3 no pending", d, 0);

    // R5 count decrements once every DIV clocks
    wr(cfg_a(2), cfg_v(1, 1));
    repeat (40) @(negedge clk);
    rd(cfg_a(2), d); chk("R5 live count", d, cfg_rb(1, 1, 256 - 10));

    // R4 first expiry time, R6 repeat in mode 1
    wr(cfg_a(2), cfg_v(1, 1));
    measure(0, 0, 5000, n); chk("R4 expiry cycle", 64'(n), 64'(expiry_cycles(1)));
    wr(A_PEND, 64'h4);
    chk("R10 w1c drops irq", cpu_irq, 0);
    measure(0, n + 1, 8000, n); chk("R6 second cpu expiry", 64'(n), 64'(2 * expiry_cycles(1)));
    chk("R6 no mgmt", mgmt_irq, 0);
    chk("R6 no reset", rst_req, 0);
    wr(cfg_a(2), cfg_v(0, 1));
    wr(A_PEND, 64'h4);

    // R10 pending set while disabled, write 0 ignored
    wr(A_ENCLR, 64'h8);
    wr(cfg_a(3), cfg_v(1, 0));
    repeat (10) @(negedge clk);
    wr(cfg_a(3), cfg_v(0, 0));
    chk("R10 disabled irq", cpu_irq, 0);
    rd(A_PEND, d); chk("R10 pending while disabled", d, 64'h8);
    wr(A_PEND, 64'h0);
    rd(A_PEND, d); chk("R10 write 0 ignored", d, 64'h8);
    wr(A_ENSET, 64'h8);
    chk("R10 enable exposes irq", cpu_irq, 1);
    wr(A_PEND, 64'h8);
    chk("R10 w1c", cpu_irq, 0);
    rd(A_PEND, d); chk("R10 pending cleared", d, 0);

    // R12 zero length, R13 prescaler restart on keepalive
    wr(cfg_a(0), cfg_v(1, 0));
    measure(0, 0, 100, n); chk("R12 zero length expiry", 64'(n), 64'(DIV));
    wr(cfg_a(0), cfg_v(0, 0));
    wr(A_PEND, 64'hF);
    wr(cfg_a(0), cfg_v(1, 0));
    repeat (2) @(negedge clk);
    wr(poke_a(0), 64'h1);
    measure(0, 0, 100, n); chk("R13 prescaler restart", 64'(n), 64'(DIV));
    wr(cfg_a(0), cfg_v(0, 0));
    wr(A_PEND, 64'hF);

    // R9 non-1 keepalives ignored, value 1 reloads
    wr(A_ENSET, 64'h2);
    wr(cfg_a(1), cfg_v(1, 1));
    t = 0;
    for (int k = 0; k < 5; k++) begin
      int w;
      logic [63:0] v;
      w = 100 + int'($urandom % 100);
      repeat (w) @(negedge clk);
      t += w;
      v = {$urandom, $urandom};
      if (v == 64'h1) v = 64'h2;
      wr(poke_a(1), v);
      t += 1;
    end
    measure(0, t, 5000, n); chk("R9 bad keepalive ignored", 64'(n), 64'(expiry_cycles(1)));
    wr(A_PEND, 64'h2);
    repeat (500) @(negedge clk);
    wr(poke_a(1), 64'h1);
    measure(0, 0, 5000, n); chk("R9 keepalive reload", 64'(n), 64'(expiry_cycles(1)));
    wr(cfg_a(1), cfg_v(0, 0));
    wr(A_PEND, 64'hF);

    // R7 mode 2 escalation
    wr(cfg_a(1), cfg_v(2, 0));
    measure(0, 0, 100, n); chk("R7 first stage cpu", 64'(n), 64'(DIV));
    measure(1, n, 100, n); chk("R7 second stage mgmt", 64'(n), 64'(2 * DIV));
    repeat (12) @(negedge clk);
    chk("R7 no reset in mode 2", rst_req, 0);
    chk("R7 mgmt held", mgmt_irq, 1);
    wr(poke_a(1), 64'h1);
    chk("R9 keepalive clears mgmt", mgmt_irq, 0);
    measure(1, 0, 100, n); chk("R9 stage restarted", 64'(n), 64'(2 * DIV));
    wr(cfg_a(1), cfg_v(0, 0));
    chk("R7 mode 0 clears mgmt", mgmt_irq, 0);
    wr(A_PEND, 64'hF);

    // R8 mode 3 reset and stickiness
    wr(cfg_a(0), cfg_v(3, 0));
    measure(2, 0, 100, n); chk("R8 third stage reset", 64'(n), 64'(3 * DIV));
    chk("R8 mgmt also raised", mgmt_irq, 1);
    wr(poke_a(0), 64'h1);
    chk("R8 sticky after keepalive", rst_req, 1);
    wr(cfg_a(0), cfg_v(0, 0));
    repeat (3) @(negedge clk);
    chk("R8 sticky after stop", rst_req, 1);
    do_reset();
    chk("R8 cleared by reset", rst_req, 0);

    // R4 random channel and length
    wr(A_ENSET, 64'hF);
    for (int k = 0; k < 4; k++) begin
      int ch, len;
      ch  = int'($urandom % NCH);
      len = int'($urandom % 3);
      wr(cfg_a(ch), cfg_v(1, len));
      measure(0, 0, 10000, n); chk("R4 random expiry", 64'(n), 64'(expiry_cycles(len)));
      rd(A_PEND, d); chk("R4 pending bit", d, 64'(1) << ch);
      wr(cfg_a(ch), cfg_v(0, 0));
      wr(A_PEND, 64'hF);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule